// File: doc/BRIEF.md
# Removable-Card Socket Status-Change Interrupt Unit

This block watches two removable-card sockets and turns activity on their status pins into latched change flags, occupancy tracking and interrupt requests. Each socket supplies two card-detect pins, two battery-voltage pins, a ready pin, a write-protect pin, an access-timeout pulse and a card interrupt request. All of these are brought into the clock domain through a two-flop synchroniser, and edges are then found by comparing against the value seen one cycle earlier.

A card counts as present only when both detect pins are high and as gone only when both are low. A per-socket occupied flag records the last decision, so a bouncing contact does not queue the same insertion or removal twice. Insertion and removal events go into a small event queue that software drains through the register port. Card interrupt requests pass to the outputs only while the socket is occupied. Latched change flags, masked by a per-socket enable, raise one of two interrupt levels chosen per socket. Any raised level also drives a single shared line.

Software reaches the block through a flat register port: a 3-bit address, a write strobe, 16-bit write data and a combinational read bus.

Top module: `card_socket_irq`

## Requirements
- R1: Each raw socket pin passes through two flops before use. A change on ready (status bit 3) or write-protect (bit 4), or a rising timeout pulse (bit 5), latches a change flag in that socket's status register (address 0 for socket 0, address 1 for socket 1). Bits 13:8 of that register read the synchronised live pins in the order detect-1, detect-2, battery-1, battery-2, ready, write-protect. Bit 14 reads the occupied flag.
- R2: A detect change that leaves both detect pins high on an unoccupied socket queues an insertion event and sets the occupied flag. Any detect change latches status bit 0.
- R3: A detect change that leaves both detect pins low on an occupied socket queues a removal event and clears the occupied flag.
- R4: A detect change that leaves the pins split, or that repeats the state the occupied flag already records, queues no event and leaves the flag unchanged.
- R5: Events are 2 bits wide: bit 0 is the kind (0 insertion, 1 removal) and bit 1 is the socket. They leave the queue in arrival order. When both sockets produce an event in the same cycle, socket 0's event enters first. Address 3 reads the oldest event in bits 1:0, non-empty in bit 8, overflow in bit 9 and the entry count from bit 10 upward. Writing bit 0 of address 3 pops one entry.
- R6: An event that arrives while the 4-entry queue is full is dropped and sets a sticky overflow flag. The occupied flag still updates. Writing bit 1 of address 3 clears the overflow flag.
- R7: A card interrupt request on an unoccupied socket is dropped: it reaches neither the card interrupt output nor status bit 6. On an occupied socket the output follows the request, and a rising request latches status bit 6.
- R8: A battery-pin change latches status bit 1 or bit 2 only when no detect change occurs on that socket in the same cycle.
- R9: Writing 1s to a status register clears the matching change bits 6:0. Writing 0s leaves them unchanged. A write of 0x3FFF clears them all.
- R10: At address 2, bit s enables socket s and bit 2+s picks its level (0 or 1). An enabled socket with any change bit set raises that level. The shared line is the OR of both levels.
- R11: After reset the status change bits, occupied flags, event queue, overflow flag, configuration and all interrupt outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cd1_i | input | 2 | First card-detect pin, one bit per socket |
| cd2_i | input | 2 | Second card-detect pin, one bit per socket |
| bvd1_i | input | 2 | Battery-voltage pin 1, per socket |
| bvd2_i | input | 2 | Battery-voltage pin 2, per socket |
| rdy_i | input | 2 | Ready/busy pin, per socket |
| wp_i | input | 2 | Write-protect pin, per socket |
| tmo_i | input | 2 | Access-timeout pulse, per socket |
| cirq_i | input | 2 | Card interrupt request, per socket |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational) |
| irq_level_o | output | 2 | Status-change interrupt levels |
| irq_o | output | 1 | Shared interrupt line |
| card_irq_o | output | 2 | Gated card interrupt, per socket |

## Verification
The bench drives one detect pin at a time and then both pins together. A design that decided presence from a single pin, or ignored the occupied flag, would queue extra insertions or duplicate ones. It fills the event queue and then sends one more event: a queue that overwrote its oldest entry, or failed to set overflow, shows a wrong drain order or a clear flag. It makes both sockets produce events in the same cycle, where a design that handled only one push per cycle would lose the socket 1 event. It also fires a card interrupt on an empty socket, and a battery change together with a detect change, where a missing gate shows up as a set status bit or a live card interrupt output.

// File: rtl/csi_pkg.sv
package csi_pkg;
    localparam int NSOCK  = 2;   // socket count; the event format assumes two
    localparam int SOCK_W = 1;
    localparam int NPIN   = 8;   // synchronised pins per socket
    localparam int NCHG   = 7;   // latched change bits per socket

    // change-bit positions inside a socket status register
    localparam int CHG_CD   = 0;
    localparam int CHG_BVD1 = 1;
    localparam int CHG_BVD2 = 2;
    localparam int CHG_RDY  = 3;
    localparam int CHG_WP   = 4;
    localparam int CHG_TMO  = 5;
    localparam int CHG_IO   = 6;

    localparam logic [2:0] ADDR_CFG = 3'd2;
    localparam logic [2:0] ADDR_EVQ = 3'd3;

    typedef struct packed {
        logic cirq;
        logic tmo;
        logic wp;
        logic rdy;
        logic bvd2;
        logic bvd1;
        logic cd2;
        logic cd1;
    } pins_t;

    typedef enum logic {
        EV_INSERT = 1'b0,
        EV_REMOVE = 1'b1
    } ev_kind_t;

    typedef struct packed {
        logic [SOCK_W-1:0] sock;
        ev_kind_t          kind;
    } event_t;
endpackage

// File: rtl/csi_sync.sv
module csi_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.s2;
endmodule

// File: rtl/csi_socket.sv
module csi_socket
    import csi_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pins_t           pins_i,
    input  logic [NCHG-1:0] clr_i,
    output logic [NCHG-1:0] chg_o,
    output logic            occ_o,
    output logic            push_o,
    output event_t          ev_o,
    output logic            cirq_o
);
    typedef struct packed {
        pins_t           prev;
        logic [NCHG-1:0] chg;
        logic            occ;
    } st_t;

    st_t             st_d, st_q;
    pins_t           delta;
    logic            cd_chg;
    logic            both_in;
    logic            both_out;
    logic [NCHG-1:0] set_bits;

    always_comb begin
        st_d     = st_q;
        delta    = pins_t'(pins_i ^ st_q.prev);
        cd_chg   = delta.cd1 | delta.cd2;
        both_in  = pins_i.cd1 & pins_i.cd2;
        both_out = ~(pins_i.cd1 | pins_i.cd2);
        push_o   = 1'b0;
        ev_o     = '{sock: SOCK_W'(IDX), kind: EV_INSERT};

        // occupancy decision: only a full transition counts, and only once
        if (cd_chg) begin
            if (both_in && !st_q.occ) begin
                push_o    = 1'b1;
                ev_o.kind = EV_INSERT;
                st_d.occ  = 1'b1;
            end else if (both_out && st_q.occ) begin
                push_o    = 1'b1;
                ev_o.kind = EV_REMOVE;
                st_d.occ  = 1'b0;
            end
        end

        set_bits           = '0;
        set_bits[CHG_CD]   = cd_chg;
        set_bits[CHG_BVD1] = delta.bvd1 & ~cd_chg;
        set_bits[CHG_BVD2] = delta.bvd2 & ~cd_chg;
        set_bits[CHG_RDY]  = delta.rdy;
        set_bits[CHG_WP]   = delta.wp;
        set_bits[CHG_TMO]  = pins_i.tmo & ~st_q.prev.tmo;
        set_bits[CHG_IO]   = pins_i.cirq & ~st_q.prev.cirq & st_q.occ;

        st_d.prev = pins_i;
        st_d.chg  = (st_q.chg & ~clr_i) | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chg_o  = st_q.chg;
    assign occ_o  = st_q.occ;
    assign cirq_o = pins_i.cirq & st_q.occ;
endmodule

// File: rtl/csi_evfifo.sv
module csi_evfifo
    import csi_pkg::*;
#(
    parameter  int DEPTH = 4,      // power of two, at least 2
    parameter  int NPUSH = 2,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NPUSH-1:0]       push_i,
    input  event_t [NPUSH-1:0]     data_i,
    input  logic                   pop_i,
    input  logic                   ovf_clr_i,
    output event_t                 head_o,
    output logic [CNT_W-1:0]       count_o,
    output logic                   ovf_o
);
    typedef struct packed {
        event_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]   rd;
        logic [CNT_W-1:0]   cnt;
        logic               ovf;
    } st_t;

    st_t  st_d, st_q;
    logic lost;

    always_comb begin
        st_d = st_q;
        lost = 1'b0;
        if (pop_i && st_q.cnt != '0) begin
            st_d.rd  = st_q.rd + PTR_W'(1);
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        // lower-numbered pusher enters first
        for (int i = 0; i < NPUSH; i++) begin
            if (push_i[i]) begin
                if (st_d.cnt < CNT_W'(DEPTH)) begin
                    st_d.mem[st_d.rd + PTR_W'(st_d.cnt)] = data_i[i];
                    st_d.cnt = st_d.cnt + CNT_W'(1);
                end else begin
                    lost = 1'b1;
                end
            end
        end
        st_d.ovf = (st_q.ovf & ~ovf_clr_i) | lost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head_o  = st_q.mem[st_q.rd];
    assign count_o = st_q.cnt;
    assign ovf_o   = st_q.ovf;
endmodule

// File: rtl/card_socket_irq.sv
module card_socket_irq
    import csi_pkg::*;
#(
    parameter  int EVQ_DEPTH = 4,
    localparam int CNT_W     = $clog2(EVQ_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSOCK-1:0] cd1_i,
    input  logic [NSOCK-1:0] cd2_i,
    input  logic [NSOCK-1:0] bvd1_i,
    input  logic [NSOCK-1:0] bvd2_i,
    input  logic [NSOCK-1:0] rdy_i,
    input  logic [NSOCK-1:0] wp_i,
    input  logic [NSOCK-1:0] tmo_i,
    input  logic [NSOCK-1:0] cirq_i,
    input  logic [2:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic [15:0]      reg_wdata_i,
    output logic [15:0]      reg_rdata_o,
    output logic [1:0]       irq_level_o,
    output logic             irq_o,
    output logic [NSOCK-1:0] card_irq_o
);
    typedef struct packed {
        logic [NSOCK-1:0] lvl;
        logic [NSOCK-1:0] en;
    } cfg_t;

    logic [NSOCK*NPIN-1:0]          raw_bus;
    logic [NSOCK*NPIN-1:0]          sync_bus;
    logic [NSOCK-1:0][NCHG-1:0]     chg;
    logic [NSOCK-1:0][NCHG-1:0]     clr;
    logic [NSOCK-1:0]               occ;
    logic [NSOCK-1:0]               push;
    event_t [NSOCK-1:0]             ev_data;
    event_t                         evq_head;
    logic [CNT_W-1:0]               evq_cnt;
    logic                           evq_ovf;
    logic                           evq_pop;
    logic                           evq_ovf_clr;
    cfg_t                           cfg_d, cfg_q;
    logic                           unused_wdata;

    assign unused_wdata = ^reg_wdata_i[15:NCHG];

    for (genvar s = 0; s < NSOCK; s++) begin : g_sock
        assign raw_bus[s*NPIN +: NPIN] = {cirq_i[s], tmo_i[s], wp_i[s], rdy_i[s],
                                          bvd2_i[s], bvd1_i[s], cd2_i[s], cd1_i[s]};

        csi_socket #(.IDX(s)) u_sock (
            .clk    (clk),
            .rst_n  (rst_n),
            .pins_i (pins_t'(sync_bus[s*NPIN +: NPIN])),
            .clr_i  (clr[s]),
            .chg_o  (chg[s]),
            .occ_o  (occ[s]),
            .push_o (push[s]),
            .ev_o   (ev_data[s]),
            .cirq_o (card_irq_o[s])
        );
    end

    csi_sync #(.W(NSOCK*NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_bus),
        .q_o   (sync_bus)
    );

    csi_evfifo #(.DEPTH(EVQ_DEPTH), .NPUSH(NSOCK)) u_evq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_i    (push),
        .data_i    (ev_data),
        .pop_i     (evq_pop),
        .ovf_clr_i (evq_ovf_clr),
        .head_o    (evq_head),
        .count_o   (evq_cnt),
        .ovf_o     (evq_ovf)
    );

    // write decode
    always_comb begin
        cfg_d       = cfg_q;
        clr         = '0;
        evq_pop     = 1'b0;
        evq_ovf_clr = 1'b0;
        if (reg_wr_i) begin
            for (int s = 0; s < NSOCK; s++) begin
                if (reg_addr_i == 3'(s)) clr[s] = reg_wdata_i[NCHG-1:0];
            end
            if (reg_addr_i == ADDR_CFG) cfg_d = cfg_t'(reg_wdata_i[2*NSOCK-1:0]);
            if (reg_addr_i == ADDR_EVQ) begin
                evq_pop     = reg_wdata_i[0];
                evq_ovf_clr = reg_wdata_i[1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    // read mux
    always_comb begin
        reg_rdata_o = '0;
        for (int s = 0; s < NSOCK; s++) begin
            if (reg_addr_i == 3'(s))
                reg_rdata_o = {1'b0, occ[s], sync_bus[s*NPIN +: 6], 1'b0, chg[s]};
        end
        if (reg_addr_i == ADDR_CFG) reg_rdata_o[2*NSOCK-1:0] = cfg_q;
        if (reg_addr_i == ADDR_EVQ) begin
            reg_rdata_o[1:0]          = evq_head;
            reg_rdata_o[8]            = (evq_cnt != '0);
            reg_rdata_o[9]            = evq_ovf;
            reg_rdata_o[10 +: CNT_W]  = evq_cnt;
        end
    end

    // interrupt routing
    always_comb begin
        irq_level_o = '0;
        for (int s = 0; s < NSOCK; s++) begin
            if (cfg_q.en[s] && (|chg[s])) irq_level_o[cfg_q.lvl[s]] = 1'b1;
        end
    end

    assign irq_o = |irq_level_o;
endmodule

// File: rtl/csi_checker.sv
module csi_checker
    import csi_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NSOCK-1:0]           occ,
    input logic [NSOCK-1:0]           card_irq,
    input logic [NSOCK-1:0][NCHG-1:0] chg,
    input logic [CNT_W-1:0]           evq_cnt,
    input logic                       evq_ovf,
    input logic [NSOCK-1:0]           cfg_en,
    input logic [1:0]                 irq_level,
    input logic                       reg_wr,
    input logic [2:0]                 reg_addr,
    input logic [NCHG-1:0]            reg_wdata
);
    assert_fifo_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evq_cnt <= CNT_W'(DEPTH));

    assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (card_irq & ~occ) == '0);

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evq_ovf && !(reg_wr && reg_addr == ADDR_EVQ && reg_wdata[1]) |=> evq_ovf);

    assert_no_irq_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en == '0 |-> irq_level == 2'b00);

    for (genvar s = 0; s < NSOCK; s++) begin : g_hold
        assert_chg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
            !(reg_wr && reg_addr == 3'(s)) |=> ((chg[s] & $past(chg[s])) == $past(chg[s])));
    end
endmodule

bind card_socket_irq csi_checker #(.DEPTH(EVQ_DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .occ       (occ),
    .card_irq  (card_irq_o),
    .chg       (chg),
    .evq_cnt   (evq_cnt),
    .evq_ovf   (evq_ovf),
    .cfg_en    (cfg_q.en),
    .irq_level (irq_level_o),
    .reg_wr    (reg_wr_i),
    .reg_addr  (reg_addr_i),
    .reg_wdata (reg_wdata_i[csi_pkg::NCHG-1:0])
);

// File: tb/tb_card_socket_irq.sv
module tb_card_socket_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cd1 = '0, cd2 = '0, bvd1 = '0, bvd2 = '0;
    logic [1:0]  rdy = '0, wp = '0, tmo = '0, cirq = '0;
    logic [2:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [1:0]  irq_level;
    logic        irq;
    logic [1:0]  card_irq;

    int checks = 0;
    int errors = 0;
    logic [15:0] v;

    always #4 clk = ~clk;

    card_socket_irq dut (
        .clk(clk), .rst_n(rst_n),
        .cd1_i(cd1), .cd2_i(cd2), .bvd1_i(bvd1), .bvd2_i(bvd2),
        .rdy_i(rdy), .wp_i(wp), .tmo_i(tmo), .cirq_i(cirq),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_level_o(irq_level), .irq_o(irq),
        .card_irq_o(card_irq)
    );

    // each entry: {s0 cd2,cd1, s1 cd2,cd1, expected occ {s1,s0}, expected queue count}
    localparam logic [8:0] VEC [7] = '{
        9'b11_00_01_001,   // R2 insert socket 0
        9'b01_00_01_001,   // R4 split detect, no event
        9'b11_00_01_001,   // R4 duplicate insert suppressed
        9'b11_10_01_001,   // R4 split on socket 1
        9'b11_11_11_010,   // R2 insert socket 1
        9'b00_11_10_011,   // R3 remove socket 0
        9'b00_00_00_100    // R3 remove socket 1, queue full
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R11 reset state
        reg_read(3'd0, v); check("R11 status0", 32'(v), 32'h0);
        reg_read(3'd1, v); check("R11 status1", 32'(v), 32'h0);
        reg_read(3'd3, v); check("R11 event queue", 32'(v), 32'h0);
        reg_read(3'd2, v); check("R11 config", 32'(v), 32'h0);
        check("R11 irq outputs", {29'h0, irq_level, irq}, 32'h0);
        check("R11 card irq", 32'(card_irq), 32'h0);

        // table walk: detect patterns, occupancy and queue depth
        for (int i = 0; i < 7; i++) begin
            {cd2[0], cd1[0], cd2[1], cd1[1]} = VEC[i][8:5];
            tick(5);
            reg_read(3'd0, v); check($sformatf("R2/R3/R4 vec%0d occ0", i), 32'(v[14]), 32'(VEC[i][3]));
            reg_read(3'd1, v); check($sformatf("R2/R3/R4 vec%0d occ1", i), 32'(v[14]), 32'(VEC[i][4]));
            reg_read(3'd3, v); check($sformatf("R5 vec%0d count", i), 32'(v[12:10]), 32'(VEC[i][2:0]));
        end

        // R6 overflow: queue full, one more insertion on socket 0
        cd1[0] = 1'b1; cd2[0] = 1'b1;
        tick(5);
        reg_read(3'd3, v);
        check("R6 overflow flag", 32'(v[9]), 32'h1);
        check("R6 count stays full", 32'(v[12:10]), 32'h4);
        reg_read(3'd0, v); check("R6 occupied still set", 32'(v[14]), 32'h1);

        // R5 drain order
        reg_read(3'd3, v); check("R5 head0 insert s0", 32'(v[1:0]), 32'h0);
        reg_write(3'd3, 16'h1);
        reg_read(3'd3, v); check("R5 head1 insert s1", 32'(v[1:0]), 32'h2);
        reg_write(3'd3, 16'h1);
        reg_read(3'd3, v); check("R5 head2 remove s0", 32'(v[1:0]), 32'h1);
        reg_write(3'd3, 16'h1);
        reg_read(3'd3, v); check("R5 head3 remove s1", 32'(v[1:0]), 32'h3);
        reg_write(3'd3, 16'h1);
        reg_read(3'd3, v); check("R5 empty after drain", 32'(v[8]), 32'h0);
        check("R6 overflow survives pops", 32'(v[9]), 32'h1);
        reg_write(3'd3, 16'h2);
        reg_read(3'd3, v); check("R6 overflow cleared", 32'(v[9]), 32'h0);

        // R5 same-cycle events: remove s0 and insert s1 together
        cd1 = 2'b10; cd2 = 2'b10;
        tick(5);
        reg_read(3'd3, v); check("R5 simultaneous count", 32'(v[12:10]), 32'h2);
        check("R5 socket0 first", 32'(v[1:0]), 32'h1);
        reg_write(3'd3, 16'h1);
        reg_read(3'd3, v); check("R5 socket1 second", 32'(v[1:0]), 32'h2);
        reg_write(3'd3, 16'h1);

        // R7 card interrupt gating (s0 empty, s1 occupied)
        reg_write(3'd0, 16'h3FFF);
        reg_write(3'd1, 16'h3FFF);
        cirq = 2'b11;
        tick(5);
        check("R7 card irq gated", 32'(card_irq), 32'h2);
        reg_read(3'd0, v); check("R7 spurious not latched", 32'(v[6]), 32'h0);
        reg_read(3'd1, v); check("R7 io bit latched", 32'(v[6]), 32'h1);
        cirq = 2'b00;
        tick(5);
        check("R7 card irq released", 32'(card_irq), 32'h0);

        // R10 routing (socket 1 has bit 6 pending, socket 0 clean)
        reg_write(3'd2, 16'h000A);
        check("R10 level1", {30'h0, irq_level}, 32'h2);
        check("R10 shared line", 32'(irq), 32'h1);
        reg_write(3'd2, 16'h0002);
        check("R10 level0", {30'h0, irq_level}, 32'h1);
        reg_write(3'd2, 16'h0001);
        check("R10 clean socket quiet", {29'h0, irq_level, irq}, 32'h0);
        reg_write(3'd2, 16'h0000);

        // R1 and R9 change bits and write-one-to-clear
        reg_write(3'd1, 16'h3FFF);
        rdy[0] = 1'b1;
        tick(5);
        reg_read(3'd0, v); check("R1 ready change", 32'(v[6:0]), 32'h08);
        reg_write(3'd0, 16'h0000);
        reg_read(3'd0, v); check("R9 zero write keeps", 32'(v[6:0]), 32'h08);
        reg_write(3'd0, 16'h0008);
        reg_read(3'd0, v); check("R9 one clears", 32'(v[6:0]), 32'h00);
        wp[1] = 1'b1; tmo[1] = 1'b1;
        tick(2);
        tmo[1] = 1'b0;
        tick(5);
        reg_read(3'd1, v); check("R1 wp and timeout", 32'(v[6:0]), 32'h30);

        // R8 battery reporting
        bvd1[0] = 1'b1;
        tick(5);
        reg_read(3'd0, v); check("R8 battery alone", 32'(v[6:0]), 32'h02);
        reg_write(3'd0, 16'h3FFF);
        cd1[0] = 1'b1; cd2[0] = 1'b1; bvd2[0] = 1'b1;
        tick(5);
        reg_read(3'd0, v);
        check("R8 battery hidden by detect", 32'(v[6:0]), 32'h01);
        check("R1 live pins", 32'(v[13:8]), 32'h1F);
        check("R2 occupied after insert", 32'(v[14]), 32'h1);
        reg_read(3'd3, v); check("R2 insert queued", 32'(v[1:0]), 32'h0);

        // R9 clear-all
        reg_write(3'd0, 16'h3FFF);
        reg_write(3'd1, 16'h3FFF);
        reg_read(3'd0, v); check("R9 clear-all s0", 32'(v[6:0]), 32'h0);
        reg_read(3'd1, v); check("R9 clear-all s1", 32'(v[6:0]), 32'h0);

        finish_run();
    end
endmodule